// File: doc/BRIEF.md
# Link-Partner Probe and Termination Sequencer

This controller decides, for four high-speed lanes arranged as two groups of two, whether each lane presents its terminations and an active output common mode, or stays parked with the receive side at high impedance, the transmit side at 1 kohm and the common mode pulled to the supply. It makes that decision by running a probe after the probe-start input has been held low long enough. Group A is lanes 0 and 1 and group B is lanes 2 and 3. The probe asks the analog front end to ramp the common mode up and then down. The comparator strobes seen during those two phases decide the state of each group.

A group counts as connected when either of its two lanes reports a receiver. Both lanes of a group therefore always share one state. A group whose probe enable is low when the probe starts is not probed and goes straight to 50 ohm. The probe enable must stay stable around the start of the probe. Any change inside that guard window sets a sticky error bit for the group. Power-down takes priority over everything else. All intervals are counted in cycles of the reference clock, and the cycle counts are parameters.

All pins are plain level control and status signals. No stream interface is involved, so no back-pressure rules apply.

Top module: `rxdet_ctrl`

## Requirements
- R1: While `pwrdn_n` is low, from the next cycle onward all lanes are parked, both ramp requests are low and any probe in progress is abandoned. The probe result and the error bits are cleared.
- R2: While `probe_rst_n` is low and `pwrdn_n` is high, from the next cycle onward all lanes are parked and both ramp requests are low.
- R3: A low pulse on `probe_rst_n` is valid when it is sampled low on at least LOW_MIN_CYC consecutive clock edges. On its rising edge exactly one probe starts. The probe drives `cm_ramp_up` for RAMP_UP_CYC cycles starting in the cycle after the rising edge, then `cm_ramp_dn` for RAMP_DN_CYC cycles, then spends one evaluate cycle, and then holds its result.
- R4: A low pulse shorter than LOW_MIN_CYC edges starts no ramp. After it ends, the outputs return to the previous result and the error bits keep their value.
- R5: Output bit i of `rx_term_on`, `tx_term_on` and `cm_active` belongs to lane i (0 and 1 form group A, 2 and 3 form group B). A 1 means 50 ohm receive, 50 ohm transmit and active common mode. A 0 means high impedance, 1 kohm and common mode at the supply. The three outputs always carry the same code. After a probe, a probed group reads 1 on both lanes if a `rcv_seen` strobe of either of its lanes was sampled during a ramp phase, and 0 on both lanes otherwise.
- R6: A `rcv_seen` strobe sampled outside the two ramp phases has no effect.
- R7: `probe_en` bit 0 controls group A and bit 1 controls group B. If a group's bit is low at the valid rising edge, the group reads 1 from the next cycle onward, both during the probe and after it, and its strobes are ignored.
- R8: If a group's `probe_en` bit is high at the valid rising edge but was not high on the EN_SETUP_CYC edges before it, that group's bit in `probe_err` is set from the next cycle onward.
- R9: A change of a group's `probe_en` bit within EN_HOLD_CYC edges after the valid rising edge sets that group's `probe_err` bit. The bit stays set until the next valid rising edge, which clears it unless that edge itself violates R8.
- R10: After reset, or after power-down is released without a valid pulse, probed groups read 0 and no ramp is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Low requests full power-down |
| probe_rst_n | input | 1 | Low holds the prober in reset; a valid rising edge starts a probe |
| probe_en | input | 2 | Per-group probe enable (bit 0 group A, bit 1 group B) |
| rcv_seen | input | 4 | Per-lane comparator strobe, 1 when a receiver was sensed |
| rx_term_on | output | 4 | Per-lane receive termination: 1 = 50 ohm, 0 = high impedance |
| tx_term_on | output | 4 | Per-lane transmit termination: 1 = 50 ohm, 0 = 1 kohm |
| cm_active | output | 4 | Per-lane common mode: 1 = held active, 0 = parked at the supply |
| cm_ramp_up | output | 1 | Probe ramp-up phase request |
| cm_ramp_dn | output | 1 | Probe ramp-down phase request |
| probe_err | output | 2 | Sticky per-group enable-window violation |

## Verification
The probe is driven with strobes on a single lane of a group during the ramp-up phase and during the ramp-down phase. This shows that the group rule applies to both lanes and that both phases count. Strobes given while the result is held show that the sampling window is closed. Pulses of exactly the minimum width and pulses one or two edges short separate a valid start from an ignored one. Enable edges placed just before the start and inside the guard window set the two error causes apart from a clean run. A power-down in the middle of a ramp exposes any state that survives the override.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  localparam int NUM_GRP    = 2;
  localparam int LANES_GRP  = 2;
  localparam int NUM_LANE   = NUM_GRP * LANES_GRP;

  typedef enum logic [2:0] {
    ST_PWRDN   = 3'd0,
    ST_HELD    = 3'd1,
    ST_RAMP_UP = 3'd2,
    ST_RAMP_DN = 3'd3,
    ST_EVAL    = 3'd4,
    ST_DONE    = 3'd5
  } det_state_t;
endpackage

// File: rtl/rxdet_lowq.sv
module rxdet_lowq #(
  parameter int LOW_MIN_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic probe_rst_n,
  output logic good_rise,
  output logic short_rise
);
  localparam int CW = $clog2(LOW_MIN_CYC + 1);
  localparam logic [CW-1:0] LOW_SAT = CW'(LOW_MIN_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= '0;
    else if (!pwrdn_n || probe_rst_n) low_cnt <= '0;
    else if (low_cnt != LOW_SAT)     low_cnt <= low_cnt + 1'b1;
  end

  assign good_rise  = pwrdn_n && probe_rst_n && (low_cnt == LOW_SAT);
  assign short_rise = pwrdn_n && probe_rst_n && (low_cnt != '0) && (low_cnt != LOW_SAT);

  AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    good_rise |-> $past(!probe_rst_n && pwrdn_n)); // R3
endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq
  import rxdet_pkg::*;
#(
  parameter int RAMP_UP_CYC = 100000,
  parameter int RAMP_DN_CYC = 188
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       probe_rst_n,
  input  logic       good_rise,
  input  logic       short_rise,
  output det_state_t st,
  output logic       ramp_up,
  output logic       ramp_dn,
  output logic       sampling,
  output logic       eval
);
  localparam int TMAX = (RAMP_UP_CYC > RAMP_DN_CYC) ? RAMP_UP_CYC : RAMP_DN_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  det_state_t    nxt;
  logic [TW-1:0] tmr, tmr_nxt;

  always_comb begin
    nxt     = st;
    tmr_nxt = tmr;
    if (!pwrdn_n)          nxt = ST_PWRDN;
    else if (!probe_rst_n) nxt = ST_HELD;
    else begin
      case (st)
        ST_PWRDN: nxt = ST_DONE;
        ST_HELD: begin
          if (good_rise) begin
            nxt     = ST_RAMP_UP;
            tmr_nxt = TW'(RAMP_UP_CYC - 1);
          end else if (short_rise) begin
            nxt = ST_DONE;
          end
        end
        ST_RAMP_UP: begin
          if (tmr == '0) begin
            nxt     = ST_RAMP_DN;
            tmr_nxt = TW'(RAMP_DN_CYC - 1);
          end else tmr_nxt = tmr - 1'b1;
        end
        ST_RAMP_DN: begin
          if (tmr == '0) nxt = ST_EVAL;
          else           tmr_nxt = tmr - 1'b1;
        end
        ST_EVAL: nxt = ST_DONE;
        default: nxt = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_PWRDN;
      tmr <= '0;
    end else begin
      st  <= nxt;
      tmr <= tmr_nxt;
    end
  end

  assign ramp_up  = (st == ST_RAMP_UP);
  assign ramp_dn  = (st == ST_RAMP_DN);
  assign sampling = ramp_up || ramp_dn;
  assign eval     = (st == ST_EVAL);

  AST_HELD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !probe_rst_n) |=> (st == ST_HELD)); // R2
  AST_DOWN_AFTER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_dn) |-> $past(ramp_up)); // R3
  AST_SHORT_NO_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    short_rise |=> !ramp_up); // R4
endmodule

// File: rtl/rxdet_grp.sv
module rxdet_grp #(
  parameter int EN_SETUP_CYC = 25,
  parameter int EN_HOLD_CYC  = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       probe_en,
  input  logic [1:0] seen,
  input  logic       good_rise,
  input  logic       sampling,
  input  logic       eval,
  output logic       found,
  output logic       en_lat,
  output logic       err
);
  localparam int SW = $clog2(EN_SETUP_CYC + 1);
  localparam int HW = $clog2(EN_HOLD_CYC + 1);
  localparam logic [SW-1:0] SETUP_SAT = SW'(EN_SETUP_CYC);

  logic [SW-1:0] hi_cnt;
  logic [HW-1:0] hold_cnt;
  logic          en_q;
  logic [1:0]    acc;

  // enable history, observed regardless of power state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= probe_en;
      if (!probe_en)               hi_cnt <= '0;
      else if (hi_cnt != SETUP_SAT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found <= 1'b0; en_lat <= 1'b1; err <= 1'b0; hold_cnt <= '0; acc <= '0;
    end else if (!pwrdn_n) begin
      found <= 1'b0; en_lat <= 1'b1; err <= 1'b0; hold_cnt <= '0; acc <= '0;
    end else if (good_rise) begin
      en_lat   <= probe_en;
      found    <= 1'b0;
      acc      <= '0;
      hold_cnt <= HW'(EN_HOLD_CYC);
      err      <= probe_en && (hi_cnt < SETUP_SAT);
    end else begin
      if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (probe_en != en_q) err <= 1'b1;
      end
      if (sampling) acc   <= acc | seen;
      if (eval)     found <= en_lat && (acc != '0);
    end
  end

  AST_NO_HIT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && eval && acc == '0) |=> !found); // R5
  AST_SKIPPED_NOT_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !good_rise && !en_lat) |=> !found); // R7
  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !good_rise && hold_cnt != '0 && probe_en != en_q) |=> err); // R9
endmodule

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
  import rxdet_pkg::*;
#(
  parameter int LOW_MIN_CYC  = 25,
  parameter int EN_SETUP_CYC = 25,
  parameter int RAMP_UP_CYC  = 100000,
  parameter int RAMP_DN_CYC  = 188,
  parameter int EN_HOLD_CYC  = 250000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwrdn_n,
  input  logic                probe_rst_n,
  input  logic [NUM_GRP-1:0]  probe_en,
  input  logic [NUM_LANE-1:0] rcv_seen,
  output logic [NUM_LANE-1:0] rx_term_on,
  output logic [NUM_LANE-1:0] tx_term_on,
  output logic [NUM_LANE-1:0] cm_active,
  output logic                cm_ramp_up,
  output logic                cm_ramp_dn,
  output logic [NUM_GRP-1:0]  probe_err
);
  det_state_t          st;
  logic                good_rise, short_rise, sampling, eval;
  logic [NUM_GRP-1:0]  found, en_lat;
  logic [NUM_LANE-1:0] lane_on;
  logic                probing;

  rxdet_lowq #(.LOW_MIN_CYC(LOW_MIN_CYC)) u_lowq (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .probe_rst_n(probe_rst_n),
    .good_rise(good_rise), .short_rise(short_rise)
  );

  rxdet_seq #(.RAMP_UP_CYC(RAMP_UP_CYC), .RAMP_DN_CYC(RAMP_DN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .probe_rst_n(probe_rst_n),
    .good_rise(good_rise), .short_rise(short_rise), .st(st),
    .ramp_up(cm_ramp_up), .ramp_dn(cm_ramp_dn), .sampling(sampling), .eval(eval)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    rxdet_grp #(.EN_SETUP_CYC(EN_SETUP_CYC), .EN_HOLD_CYC(EN_HOLD_CYC)) u_grp (
      .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .probe_en(probe_en[g]),
      .seen(rcv_seen[g*LANES_GRP +: LANES_GRP]), .good_rise(good_rise),
      .sampling(sampling), .eval(eval),
      .found(found[g]), .en_lat(en_lat[g]), .err(probe_err[g])
    );
  end

  assign probing = (st == ST_RAMP_UP) || (st == ST_RAMP_DN) || (st == ST_EVAL);

  // a lane follows its group: skipped groups terminate, probed groups wait for the result
  for (genvar c = 0; c < NUM_LANE; c++) begin : g_lane
    localparam int G = c / LANES_GRP;
    assign lane_on[c] = (st == ST_DONE) ? (!en_lat[G] || found[G])
                                        : (probing && !en_lat[G]);
  end

  assign rx_term_on = lane_on;
  assign tx_term_on = lane_on;
  assign cm_active  = lane_on;

  AST_PWRDN_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (rx_term_on == '0 && tx_term_on == '0 && cm_active == '0
                  && !cm_ramp_up && !cm_ramp_dn)); // R1
  AST_HELD_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !probe_rst_n) |=> (rx_term_on == '0 && !cm_ramp_up && !cm_ramp_dn)); // R2
endmodule

// File: tb/rxdet_ctrl_test.sv
module rxdet_ctrl_test;
  localparam int P_LOW = 4, P_SETUP = 3, P_UP = 12, P_DN = 3, P_HOLD = 20;

  logic clk = 1'b0, rst_n = 1'b0, pwrdn_n = 1'b1, probe_rst_n = 1'b1;
  logic [1:0] probe_en = 2'b11;
  logic [3:0] rcv_seen = 4'b0;
  logic [3:0] rx_term_on, tx_term_on, cm_active;
  logic       cm_ramp_up, cm_ramp_dn;
  logic [1:0] probe_err;

  int    n_chk = 0, n_err = 0;
  string cur_tag = "R10";
  bit    finished = 0;

  always #4 clk = ~clk;

  rxdet_ctrl #(.LOW_MIN_CYC(P_LOW), .EN_SETUP_CYC(P_SETUP), .RAMP_UP_CYC(P_UP),
               .RAMP_DN_CYC(P_DN), .EN_HOLD_CYC(P_HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .probe_rst_n(probe_rst_n),
    .probe_en(probe_en), .rcv_seen(rcv_seen), .rx_term_on(rx_term_on),
    .tx_term_on(tx_term_on), .cm_active(cm_active), .cm_ramp_up(cm_ramp_up),
    .cm_ramp_dn(cm_ramp_dn), .probe_err(probe_err)
  );

  // behavioural reference: mode 0 off,1 held,2 up,3 down,4 eval,5 result
  int m_st, m_low, m_tmr;
  int m_hi[2], m_hold[2];
  bit m_enq[2], m_enl[2], m_fnd[2], m_err[2], m_acc[2];
  bit vr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_low = 0; m_tmr = 0;
      for (int g = 0; g < 2; g++) begin
        m_hi[g] = 0; m_hold[g] = 0; m_enq[g] = 0; m_enl[g] = 1;
        m_fnd[g] = 0; m_err[g] = 0; m_acc[g] = 0;
      end
    end else begin
      vr = pwrdn_n && probe_rst_n && (m_low >= P_LOW);
      for (int g = 0; g < 2; g++) begin
        if (!pwrdn_n) begin
          m_enl[g] = 1; m_fnd[g] = 0; m_err[g] = 0; m_hold[g] = 0; m_acc[g] = 0;
        end else if (vr) begin
          m_enl[g] = probe_en[g]; m_fnd[g] = 0; m_acc[g] = 0; m_hold[g] = P_HOLD;
          m_err[g] = probe_en[g] && (m_hi[g] < P_SETUP);
        end else begin
          if (m_hold[g] > 0) begin
            if (probe_en[g] != m_enq[g]) m_err[g] = 1;
            m_hold[g]--;
          end
          if (m_st == 2 || m_st == 3) m_acc[g] = m_acc[g] | rcv_seen[2*g] | rcv_seen[2*g+1];
          if (m_st == 4) m_fnd[g] = m_enl[g] && m_acc[g];
        end
        if (probe_en[g]) begin if (m_hi[g] < P_SETUP) m_hi[g]++; end
        else m_hi[g] = 0;
        m_enq[g] = probe_en[g];
      end
      if (!pwrdn_n) m_st = 0;
      else if (!probe_rst_n) m_st = 1;
      else case (m_st)
        0: m_st = 5;
        1: if (vr) begin m_st = 2; m_tmr = P_UP - 1; end else m_st = 5;
        2: if (m_tmr == 0) begin m_st = 3; m_tmr = P_DN - 1; end else m_tmr--;
        3: if (m_tmr == 0) m_st = 4; else m_tmr--;
        4: m_st = 5;
        default: ;
      endcase
      if (!pwrdn_n || probe_rst_n) m_low = 0;
      else if (m_low < P_LOW) m_low++;
    end
  end

  function automatic logic [3:0] exp_on();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) begin
      if (m_st == 0 || m_st == 1) v[c] = 1'b0;
      else if (m_st == 5)         v[c] = !m_enl[c/2] || m_fnd[c/2];
      else                        v[c] = !m_enl[c/2];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished)
      chk(cur_tag, {rx_term_on, tx_term_on, cm_active, cm_ramp_up, cm_ramp_dn, probe_err},
          {exp_on(), exp_on(), exp_on(), m_st == 2, m_st == 3, m_err[1], m_err[0]});
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int low);
    probe_rst_n = 1'b0; step(low); probe_rst_n = 1'b1; step(1);
  endtask

  task automatic run_probe(input logic [3:0] in_up, input logic [3:0] in_dn,
                           output int nup, output int ndn);
    nup = 0; ndn = 0;
    while (cm_ramp_up && nup < 1000) begin
      rcv_seen = (nup == 0) ? in_up : 4'b0; step(1); nup++;
    end
    rcv_seen = 4'b0;
    while (cm_ramp_dn && ndn < 1000) begin
      rcv_seen = (ndn == 0) ? in_dn : 4'b0; step(1); ndn++;
    end
    rcv_seen = 4'b0; step(2);
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int nup, ndn;
    bit saw;
    step(3); rst_n = 1'b1; step(3);
    cur_tag = "R10";
    chk("R10 reset lanes", rx_term_on, 4'b0000);
    chk("R10 reset ramp", {cm_ramp_up, cm_ramp_dn}, 2'b00);

    // R3/R5: minimum-width pulse, lane A0 seen during ramp-up
    cur_tag = "R3";
    probe_rst_n = 1'b0; step(1);
    chk("R2 held parks", {rx_term_on, cm_ramp_up}, 5'b0);
    step(P_LOW - 1); probe_rst_n = 1'b1; step(1);
    chk("R3 ramp starts", cm_ramp_up, 1'b1);
    run_probe(4'b0001, 4'b0000, nup, ndn);
    chk("R3 ramp up length", nup, P_UP);
    chk("R3 ramp down length", ndn, P_DN);
    cur_tag = "R5";
    chk("R5 group A on", {rx_term_on, tx_term_on, cm_active}, 12'h333);
    step(6);
    chk("R3 single probe", {cm_ramp_up, cm_ramp_dn}, 2'b00);

    // R4: short pulse ignored
    cur_tag = "R4";
    saw = 0;
    probe_rst_n = 1'b0; step(P_LOW - 1); probe_rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin step(1); if (cm_ramp_up) saw = 1; end
    chk("R4 no ramp", saw, 1'b0);
    chk("R4 result kept", rx_term_on, 4'b0011);

    // R6: strobes while holding the result
    cur_tag = "R6";
    rcv_seen = 4'b1111; step(2); rcv_seen = 4'b0; step(2);
    chk("R6 late strobe ignored", rx_term_on, 4'b0011);

    // R5: only lane B1, seen during ramp-down
    cur_tag = "R5";
    step(P_HOLD);
    pulse(P_LOW + 2);
    run_probe(4'b0000, 4'b1000, nup, ndn);
    chk("R5 group B on", rx_term_on, 4'b1100);

    // R7: group B skipped, its strobes ignored
    cur_tag = "R7";
    step(P_HOLD + 5);
    probe_en = 2'b01; step(P_SETUP + 2);
    pulse(P_LOW);
    chk("R7 skipped group on during probe", rx_term_on, 4'b1100);
    run_probe(4'b1100, 4'b1000, nup, ndn);
    chk("R7 skipped group result", rx_term_on, 4'b1100);
    chk("R7 no flags", probe_err, 2'b00);

    // R8: enable raised too close to the start edge
    cur_tag = "R8";
    step(P_HOLD + 5);
    probe_rst_n = 1'b0; step(P_LOW - 1); probe_en = 2'b11; step(1);
    probe_rst_n = 1'b1; step(1);
    chk("R8 setup flag", probe_err, 2'b10);
    run_probe(4'b0000, 4'b0000, nup, ndn);

    // R9: clean start clears the flag, toggle inside guard sets it
    cur_tag = "R9";
    step(P_HOLD + 5);
    pulse(P_LOW);
    chk("R9 cleared by valid start", probe_err, 2'b00);
    probe_en = 2'b10; step(1); probe_en = 2'b11;
    run_probe(4'b0010, 4'b0000, nup, ndn);
    step(P_HOLD);
    chk("R9 sticky flag", probe_err, 2'b01);
    chk("R9 result unaffected", rx_term_on, 4'b0011);
    pulse(P_LOW);
    chk("R9 next start clears", probe_err, 2'b00);
    run_probe(4'b0100, 4'b0000, nup, ndn);

    // R1: power-down mid ramp
    cur_tag = "R1";
    step(P_HOLD + 5);
    pulse(P_LOW);
    step(3);
    pwrdn_n = 1'b0; step(1);
    chk("R1 parked", {rx_term_on, tx_term_on, cm_active, cm_ramp_up, cm_ramp_dn}, 14'h0);
    rcv_seen = 4'b1111; step(3); rcv_seen = 4'b0;
    chk("R1 still parked", rx_term_on, 4'b0000);
    cur_tag = "R10";
    pwrdn_n = 1'b1; step(3);
    chk("R10 after release", {rx_term_on, cm_ramp_up, cm_ramp_dn}, 6'b0);
    step(2);

    summary();
    $finish;
  end
endmodule